// File: doc/BRIEF.md
# Flash Read Address Offset Remapper

This block sits on the path from the system bus to the flash controller and moves read accesses that land in a programmable page window. The flash is visible at two 32 MB aliases: a non-secure one at 0x08000000 and a secure one at 0x0C000000. When remapping is enabled and a read hits the window, the block adds a page-granular offset to the address inside the alias. The alias bits are left as they were.

Program and erase requests, reads outside the window and addresses outside both aliases reach the flash interface unchanged. The same remapping applies whether the flash behind the aliases is on-package or attached over QSPI.

The window and offset come from a small configuration register. That register accepts a write only while the option-write permission input is high. Each request gets its answer one clock later.

Top module: `flash_read_remap`

## Requirements
- R1: While reset is active and after it is released, rsp_valid, rsp_hit and rsp_addr are 0, and the configuration is cleared, so remapping is disabled.
- R2: A request presented with req_valid high in one cycle produces rsp_valid high in the next cycle. A cycle with req_valid low produces rsp_valid low, rsp_addr 0 and rsp_hit 0 in the next cycle. Back-to-back requests are answered back to back.
- R3: A read (req_op 2'b00) with remapping enabled, in the non-secure alias (address bits 31:25 equal 7'h04), whose page (address bits 24:12) lies in [start, end] inclusive, returns rsp_hit 1. rsp_addr is then 0x08000000 plus ((address bits 24:0) + offset×4096) modulo 2^25.
- R4: The same remapping applies to the secure alias (address bits 31:25 equal 7'h06), and rsp_addr keeps the secure alias bits.
- R5: The addition wraps modulo 32 MB inside the alias. A remapped address never leaves its alias.
- R6: Program (req_op 2'b01) and erase (req_op 2'b10) requests, and the reserved code 2'b11, return the request address unchanged with rsp_hit 0, even inside an enabled window.
- R7: Addresses outside both aliases return unchanged with rsp_hit 0.
- R8: With the enable bit at 0, every request returns unchanged with rsp_hit 0.
- R9: A configuration write (cfg_we high) is taken only when cfg_perm is high in the same cycle, and it affects requests from the next cycle on. A write with cfg_perm low leaves the configuration as it was.
- R10: Reads whose page is below start or above end return unchanged with rsp_hit 0. A window with start greater than end matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_perm | input | 1 | Option-write permission; a write is taken only while high |
| cfg_en_i | input | 1 | Remapping enable to store |
| cfg_start_i | input | 13 | First page of the window |
| cfg_end_i | input | 13 | Last page of the window |
| cfg_off_i | input | 13 | Offset in 4 KB pages |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 reserved |
| req_addr | input | 32 | Bus address |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_addr | output | 32 | Address for the flash interface |
| rsp_hit | output | 1 | The offset was applied |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 25-bit alias field and 4 KB pages, which give 13-bit page numbers. With these widths the top page 0x1FFF and the wrap past the end of an alias can be reached with small offsets. The same setting covers both window edges in either alias and a window with start above end. A reference model in the bench predicts every output on every clock, so configuration writes that land in the same cycle as a request are checked as well.

// File: rtl/frr_pkg.sv
package frr_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } frr_op_e;

    localparam int unsigned FRR_ADDR_W    = 32;
    localparam int unsigned FRR_WIN_BITS  = 25;
    localparam int unsigned FRR_PAGE_BITS = 12;

endpackage

// File: rtl/frr_cfg.sv
module frr_cfg #(
    parameter int unsigned PG_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            perm,
    input  logic            en_i,
    input  logic [PG_W-1:0] start_i,
    input  logic [PG_W-1:0] end_i,
    input  logic [PG_W-1:0] off_i,
    output logic            en_o,
    output logic [PG_W-1:0] start_o,
    output logic [PG_W-1:0] end_o,
    output logic [PG_W-1:0] off_o
);

    typedef struct packed {
        logic            en;
        logic [PG_W-1:0] start_pg;
        logic [PG_W-1:0] end_pg;
        logic [PG_W-1:0] off_pg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && perm) begin
            cfg_d.en       = en_i;
            cfg_d.start_pg = start_i;
            cfg_d.end_pg   = end_i;
            cfg_d.off_pg   = off_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o    = cfg_q.en;
    assign start_o = cfg_q.start_pg;
    assign end_o   = cfg_q.end_pg;
    assign off_o   = cfg_q.off_pg;

endmodule

// File: rtl/frr_match.sv
module frr_match
    import frr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WIN_BITS  = 25,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned NUM_ALIAS = 2,
    parameter logic [NUM_ALIAS-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h0C00_0000, 32'h0800_0000},
    localparam int unsigned PG_W  = WIN_BITS - PAGE_BITS,
    localparam int unsigned TAG_W = ADDR_W - WIN_BITS
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        op_i,
    input  logic              en_i,
    input  logic [PG_W-1:0]   start_i,
    input  logic [PG_W-1:0]   end_i,
    input  logic [PG_W-1:0]   off_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [NUM_ALIAS-1:0] tag_hit;
    logic [TAG_W-1:0]     tag;
    logic [PG_W-1:0]      page;
    logic [WIN_BITS-1:0]  moved;
    logic                 in_alias;
    logic                 in_win;
    logic                 is_read;

    assign tag  = addr_i[ADDR_W-1:WIN_BITS];
    assign page = addr_i[WIN_BITS-1:PAGE_BITS];

    for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
        assign tag_hit[g] = (tag == ALIAS_BASE[g][ADDR_W-1:WIN_BITS]);
    end

    always_comb begin
        in_alias = |tag_hit;
        in_win   = (page >= start_i) && (page <= end_i);
        is_read  = (frr_op_e'(op_i) == OP_READ);
        hit_o    = en_i && is_read && in_alias && in_win;
        moved    = addr_i[WIN_BITS-1:0] + {off_i, {PAGE_BITS{1'b0}}};
        addr_o   = hit_o ? {tag, moved} : addr_i;
    end

endmodule

// File: rtl/flash_read_remap.sv
module flash_read_remap
    import frr_pkg::*;
#(
    parameter int unsigned ADDR_W    = FRR_ADDR_W,
    parameter int unsigned WIN_BITS  = FRR_WIN_BITS,
    parameter int unsigned PAGE_BITS = FRR_PAGE_BITS,
    localparam int unsigned PG_W     = WIN_BITS - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_perm,
    input  logic              cfg_en_i,
    input  logic [PG_W-1:0]   cfg_start_i,
    input  logic [PG_W-1:0]   cfg_end_i,
    input  logic [PG_W-1:0]   cfg_off_i,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_hit
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              hit;
    } rsp_t;

    logic              cfg_en_q;
    logic [PG_W-1:0]   cfg_start_q;
    logic [PG_W-1:0]   cfg_end_q;
    logic [PG_W-1:0]   cfg_off_q;
    logic              map_hit;
    logic [ADDR_W-1:0] map_addr;
    rsp_t              rsp_d, rsp_q;

    frr_cfg #(.PG_W(PG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .perm    (cfg_perm),
        .en_i    (cfg_en_i),
        .start_i (cfg_start_i),
        .end_i   (cfg_end_i),
        .off_i   (cfg_off_i),
        .en_o    (cfg_en_q),
        .start_o (cfg_start_q),
        .end_o   (cfg_end_q),
        .off_o   (cfg_off_q)
    );

    frr_match #(
        .ADDR_W    (ADDR_W),
        .WIN_BITS  (WIN_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_match (
        .addr_i  (req_addr),
        .op_i    (req_op),
        .en_i    (cfg_en_q),
        .start_i (cfg_start_q),
        .end_i   (cfg_end_q),
        .off_i   (cfg_off_q),
        .hit_o   (map_hit),
        .addr_o  (map_addr)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.addr = map_addr;
            rsp_d.hit  = map_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_hit   = rsp_q.hit;

endmodule

// File: rtl/frr_checker.sv
module frr_checker #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WIN_BITS  = 25,
    parameter int unsigned PAGE_BITS = 12,
    localparam int unsigned PG_W     = WIN_BITS - PAGE_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_perm,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_hit,
    input logic              en_q,
    input logic [PG_W-1:0]   start_q,
    input logic [PG_W-1:0]   end_q,
    input logic [PG_W-1:0]   off_q
);

    logic [PG_W-1:0] req_page;
    assign req_page = req_addr[WIN_BITS-1:PAGE_BITS];

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && rsp_addr == '0));

    p_alias_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr[ADDR_W-1:WIN_BITS] == $past(req_addr[ADDR_W-1:WIN_BITS])));

    p_write_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b00) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

    p_off_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !en_q) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

    p_locked_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_perm) |=> ($stable(en_q) && $stable(start_q)
                                   && $stable(end_q) && $stable(off_q)));

    p_outside_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_page < start_q || req_page > end_q)) |=> !rsp_hit);

endmodule

bind flash_read_remap frr_checker #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_perm  (cfg_perm),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_hit   (rsp_hit),
    .en_q      (cfg_en_q),
    .start_q   (cfg_start_q),
    .end_q     (cfg_end_q),
    .off_q     (cfg_off_q)
);

// File: tb/test_flash_read_remap.sv
`timescale 1ns/1ps
module test_flash_read_remap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_perm = 1'b0;
    logic        cfg_en_i = 1'b0;
    logic [12:0] cfg_start_i = '0;
    logic [12:0] cfg_end_i = '0;
    logic [12:0] cfg_off_i = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_hit;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R1";

    // model state
    bit          m_en;
    int unsigned m_start, m_end, m_off;
    bit          e_v, e_h;
    logic [31:0] e_a;

    always #2.5 clk = ~clk;

    flash_read_remap i_flash_read_remap (
        .clk, .rst_n, .cfg_we, .cfg_perm, .cfg_en_i, .cfg_start_i, .cfg_end_i,
        .cfg_off_i, .req_valid, .req_op, .req_addr, .rsp_valid, .rsp_addr, .rsp_hit
    );

    function automatic void predict(input logic [31:0] a, input logic [1:0] op);
        int unsigned alias_id, pg, low;
        alias_id = a >> 25;
        pg       = (a >> 12) & 32'h1FFF;
        e_v = 1'b1;
        e_h = 1'b0;
        e_a = a;
        if (m_en && op == 2'b00 && (alias_id == 4 || alias_id == 6)
            && pg >= m_start && pg <= m_end) begin
            low = ((a & 32'h01FF_FFFF) + (m_off << 12)) & 32'h01FF_FFFF;
            e_h = 1'b1;
            e_a = (alias_id << 25) | low;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_v = 0; e_h = 0; e_a = '0;
            m_en = 0; m_start = 0; m_end = 0; m_off = 0;
        end else begin
            if (req_valid) predict(req_addr, req_op);
            else begin e_v = 0; e_h = 0; e_a = '0; end
            if (cfg_we && cfg_perm) begin
                m_en = cfg_en_i; m_start = cfg_start_i;
                m_end = cfg_end_i; m_off = cfg_off_i;
            end
        end
        #1;
        if (!done) begin
            checks++;
            if (rsp_valid !== e_v || rsp_hit !== e_h || rsp_addr !== e_a) begin
                errors++;
                $display("FAIL %s: got v=%0b a=%h h=%0b, expected v=%0b a=%h h=%0b",
                         tag, rsp_valid, rsp_addr, rsp_hit, e_v, e_a, e_h);
            end
        end
    end

    task automatic rd(input logic [1:0] op, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cfg(input bit perm, input bit en, input int unsigned s,
                       input int unsigned e, input int unsigned o);
        @(negedge clk);
        cfg_we = 1'b1; cfg_perm = perm; cfg_en_i = en;
        cfg_start_i = 13'(s); cfg_end_i = 13'(e); cfg_off_i = 13'(o);
        @(negedge clk);
        cfg_we = 1'b0; cfg_perm = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state, cleared config gives passthrough
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        rd(2'b00, 32'h0801_5000);
        idle(1);

        // R9: write without permission is ignored
        tag = "R9";
        cfg(1'b0, 1'b1, 32'h010, 32'h020, 32'h100);
        rd(2'b00, 32'h0801_5000);
        cfg(1'b1, 1'b1, 32'h010, 32'h020, 32'h100);
        rd(2'b00, 32'h0801_5004);
        idle(1);
        // R9: write and request in the same cycle use the old config
        @(negedge clk);
        cfg_we = 1'b1; cfg_perm = 1'b1; cfg_en_i = 1'b1;
        cfg_start_i = 13'h010; cfg_end_i = 13'h020; cfg_off_i = 13'h200;
        req_valid = 1'b1; req_op = 2'b00; req_addr = 32'h0801_8000;
        @(negedge clk);
        cfg_we = 1'b0; cfg_perm = 1'b0; req_valid = 1'b0;
        rd(2'b00, 32'h0801_8000);
        cfg(1'b1, 1'b1, 32'h010, 32'h020, 32'h100);

        // R3: non-secure window edges and middle
        tag = "R3";
        rd(2'b00, 32'h0801_0000);
        rd(2'b00, 32'h0801_5ABC);
        rd(2'b00, 32'h0802_0FFF);

        // R4: secure alias
        tag = "R4";
        rd(2'b00, 32'h0C01_0000);
        rd(2'b00, 32'h0C01_7123);
        rd(2'b00, 32'h0C02_0FFC);

        // R10: just outside, then empty window
        tag = "R10";
        rd(2'b00, 32'h0800_FFFF);
        rd(2'b00, 32'h0802_1000);
        rd(2'b00, 32'h0C00_F000);
        cfg(1'b1, 1'b1, 32'h050, 32'h040, 32'h001);
        rd(2'b00, 32'h0804_8000);
        rd(2'b00, 32'h0805_0000);

        // R5: wrap at top of alias
        tag = "R5";
        cfg(1'b1, 1'b1, 32'h100, 32'h1FFF, 32'h1F80);
        rd(2'b00, 32'h09FF_0010);
        rd(2'b00, 32'h0DFF_FFFF);
        rd(2'b00, 32'h0810_0000);

        // R6: program, erase, reserved in window
        tag = "R6";
        rd(2'b01, 32'h09FF_0010);
        rd(2'b10, 32'h0C20_0000);
        rd(2'b11, 32'h0850_0000);

        // R7: outside both aliases
        tag = "R7";
        rd(2'b00, 32'h0000_0000);
        rd(2'b00, 32'h0A10_0000);
        rd(2'b00, 32'h1010_0000);
        rd(2'b00, 32'h07FF_FFFF);

        // R2: bubbles and back-to-back
        tag = "R2";
        idle(2);
        rd(2'b00, 32'h0810_0000);
        idle(1);
        rd(2'b00, 32'h0C10_0000);
        rd(2'b01, 32'h0C10_0000);

        // R8: disabled
        tag = "R8";
        cfg(1'b1, 1'b0, 32'h000, 32'h1FFF, 32'h0123);
        rd(2'b00, 32'h0810_0000);
        rd(2'b00, 32'h0C00_0000);
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule